// File: doc/BRIEF.md
# Serial Strobe Control Register

This block holds the signed window-offset setting for a data synchronizer. A host, or fixed wiring, moves a seven-bit control frame in one bit at a time. Each rising edge of a serial clock moves in one bit while the control-register enable is active. A separate holding latch drives the outputs. The latch keeps its old contents while a new frame is being shifted in. It takes the shifted frame only when the read-gate input rises. So a new offset never takes effect in the middle of a read.

The frame is sign-magnitude. The outputs are the magnitude, a direction flag (Early or Late), a factory-test flag and the decoded two's-complement offset in unit steps. In bypass mode the read gate also serves as the shift enable and the serial data is forced to zero. Powering up with the read gate low, clocking the serial line and then raising the read gate therefore gives the nominal zero offset. All inputs are taken to be synchronous to `clk_i`. The serial clock and the read gate are edge-detected in that domain.

Top module: `strobe_ctrl_reg`

## Requirements
- R1: After reset, mag_o, late_o, test_mode_o and offset_o are all zero, and the shift stage holds all zeros.
- R2: The frame is 7 bits and is shifted in test bit first, then the direction bit, then the magnitude from MSB to LSB. A bit moves in on each detected rising edge of sclk_i while shifting is allowed. When more than 7 bits arrive, only the last 7 are kept.
- R3: While a frame is being shifted, the outputs keep the previously latched setting.
- R4: The latch takes the shift-stage contents only in the cycle where read_gate_i is sampled high after being sampled low. The new outputs are visible from the following cycle. A steady-high or a falling read gate does not reload the latch.
- R5: While read_gate_i is high, no bit enters the shift stage, even when the enable is active and sclk_i toggles.
- R6: Outside bypass mode, sclk_i edges have no effect while cr_en_i is low.
- R7: mag_o carries the 5-bit magnitude. late_o carries the direction bit, where 1 means Late and 0 means Early.
- R8: offset_o is a 6-bit two's-complement value. It equals +M for Late and −M for Early, and it is 0 whenever M is 0, whatever the direction bit.
- R9: test_mode_o is high exactly when the latched test bit is 1.
- R10: With bypass_i high, shifting is enabled whenever read_gate_i is low, regardless of cr_en_i, and the shifted-in bits are zero. Raising read_gate_i then latches the nominal setting: all outputs are zero.
- R11: When an sclk_i rising edge and a read_gate_i rising edge fall in the same cycle, the read gate wins. The bit is not shifted, and the latch takes the frame as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | Hardwired mode: read gate acts as shift enable, data forced to zero |
| cr_en_i | input | 1 | Control-register shift enable |
| sclk_i | input | 1 | Serial clock, one bit per rising edge |
| sdata_i | input | 1 | Serial data |
| read_gate_i | input | 1 | Read gate; a rising edge transfers the frame to the latch |
| mag_o | output | 5 | Latched offset magnitude |
| late_o | output | 1 | Latched direction, 1 = Late |
| test_mode_o | output | 1 | Latched factory-test flag |
| offset_o | output | 6 | Signed offset in unit steps |

## Verification
A serial-clock rising edge and a read-gate rising edge can be sampled in the same cycle. In that case the block has to choose between shifting the bit and transferring the frame. The bench loads a known frame, then drives sclk_i and read_gate_i high on the same clock edge, with a data bit that would visibly change the frame. The latched result must equal the frame from before that edge, so the sign, magnitude and test fields are compared against the unshifted frame.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic {
    DIR_EARLY = 1'b0,
    DIR_LATE  = 1'b1
  } strobe_dir_e;

  function automatic int frame_bits(input int mag_w);
    return mag_w + 2;
  endfunction
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/strobe_shift_stage.sv
module strobe_shift_stage #(
  parameter int MAG_W = 5,
  localparam int FW = strobe_pkg::frame_bits(MAG_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          en_i,
  input  logic          inhibit_i,
  input  logic          bit_i,
  output logic [FW-1:0] frame_o
);
  logic [FW-1:0] frame_q;
  logic          do_shift;

  assign do_shift = step_i & en_i & ~inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       frame_q <= '0;
    else if (do_shift) frame_q <= {frame_q[FW-2:0], bit_i};
  end

  assign frame_o = frame_q;

  // R5 R11
  read_gate_blocks_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> $stable(frame_q));

  // R6
  no_enable_no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(frame_q));

  // R2
  shift_takes_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && en_i && !inhibit_i) |=> (frame_q[0] == $past(bit_i)));
endmodule

// File: rtl/strobe_hold_latch.sv
module strobe_hold_latch #(
  parameter int MAG_W = 5,
  localparam int FW = strobe_pkg::frame_bits(MAG_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [FW-1:0] frame_i,
  output logic [FW-1:0] frame_o
);
  logic [FW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= frame_i;
  end

  assign frame_o = hold_q;

  // R3
  hold_without_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hold_q));

  // R4
  load_captures_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hold_q == $past(frame_i)));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode #(
  parameter int MAG_W = 5,
  localparam int FW = strobe_pkg::frame_bits(MAG_W)
) (
  input  logic                    [FW-1:0]  frame_i,
  output logic                    [MAG_W-1:0] mag_o,
  output strobe_pkg::strobe_dir_e           dir_o,
  output logic                              test_o,
  output logic signed             [MAG_W:0] offset_o
);
  logic signed [MAG_W:0] mag_ext;

  // frame layout: [FW-1]=test, [FW-2]=direction, [MAG_W-1:0]=magnitude, MSB first on the wire
  assign test_o  = frame_i[FW-1];
  assign dir_o   = strobe_pkg::strobe_dir_e'(frame_i[FW-2]);
  assign mag_o   = frame_i[MAG_W-1:0];
  assign mag_ext = $signed({1'b0, mag_o});

  always_comb begin
    if (dir_o == strobe_pkg::DIR_LATE) offset_o = mag_ext;
    else                               offset_o = -mag_ext;
  end
endmodule

// File: rtl/strobe_ctrl_reg.sv
module strobe_ctrl_reg #(
  parameter int MAG_W = 5,
  localparam int FW = strobe_pkg::frame_bits(MAG_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bypass_i,
  input  logic               cr_en_i,
  input  logic               sclk_i,
  input  logic               sdata_i,
  input  logic               read_gate_i,
  output logic [MAG_W-1:0]   mag_o,
  output logic               late_o,
  output logic               test_mode_o,
  output logic [MAG_W:0]     offset_o
);
  logic [1:0]    rise;
  logic          sclk_rise, rg_rise;
  logic          shift_en, shift_bit;
  logic [FW-1:0] shift_frame, held_frame;
  strobe_pkg::strobe_dir_e dir;
  logic signed [MAG_W:0] offset_s;

  rise_detect #(.W(2)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({read_gate_i, sclk_i}),
    .rise_o(rise)
  );
  assign sclk_rise = rise[0];
  assign rg_rise   = rise[1];

  // bypass: read gate low acts as enable, zeros enter
  assign shift_en  = bypass_i | cr_en_i;
  assign shift_bit = bypass_i ? 1'b0 : sdata_i;

  strobe_shift_stage #(.MAG_W(MAG_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (sclk_rise),
    .en_i     (shift_en),
    .inhibit_i(read_gate_i),
    .bit_i    (shift_bit),
    .frame_o  (shift_frame)
  );

  strobe_hold_latch #(.MAG_W(MAG_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rg_rise),
    .frame_i(shift_frame),
    .frame_o(held_frame)
  );

  strobe_decode #(.MAG_W(MAG_W)) u_dec (
    .frame_i (held_frame),
    .mag_o   (mag_o),
    .dir_o   (dir),
    .test_o  (test_mode_o),
    .offset_o(offset_s)
  );

  assign late_o   = (dir == strobe_pkg::DIR_LATE);
  assign offset_o = offset_s;

  // R8
  zero_mag_zero_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_o == '0) |-> (offset_o == '0));

  // R8
  early_negative_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!late_o && mag_o != '0) |-> offset_s < 0);

  // R10
  bypass_zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_i && sclk_rise && !read_gate_i) |=> (shift_frame[0] == 1'b0));

  // R4
  outputs_change_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(held_frame) |-> $past(rg_rise));
endmodule

// File: tb/strobe_ctrl_reg_test.sv
module strobe_ctrl_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass = 1'b0, cr_en = 1'b0, sclk = 1'b0, sdata = 1'b0, rg = 1'b0;
  logic [4:0] mag;
  logic       late, tmode;
  logic [5:0] offset;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_ctrl_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .cr_en_i(cr_en),
    .sclk_i(sclk), .sdata_i(sdata), .read_gate_i(rg),
    .mag_o(mag), .late_o(late), .test_mode_o(tmode), .offset_o(offset)
  );

  function automatic logic [6:0] mk(input logic t, input logic s, input logic [4:0] m);
    return {t, s, m};
  endfunction

  task automatic expect_frame(input logic [6:0] f, input string req);
    logic signed [5:0] exp_off;
    exp_off = f[5] ? $signed({1'b0, f[4:0]}) : -$signed({1'b0, f[4:0]});
    n_chk++;
    if (mag !== f[4:0] || late !== f[5] || tmode !== f[6] || $signed(offset) !== exp_off) begin
      n_bad++;
      $display("FAIL %s: got mag=%0d late=%0b test=%0b off=%0d, exp mag=%0d late=%0b test=%0b off=%0d",
               req, mag, late, tmode, $signed(offset), f[4:0], f[5], f[6], exp_off);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic send_frame(input logic [6:0] f);
    for (int i = 6; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_rg();
    @(negedge clk); rg = 1'b1;
    @(negedge clk);
  endtask

  task automatic drop_rg();
    @(negedge clk); rg = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_frame(7'b0, "R1 reset");
    pulse_rg(); drop_rg();
    expect_frame(7'b0, "R1 shift stage zero");
  endtask

  task automatic t_late_load();
    cr_en = 1'b1;
    send_frame(mk(0, 1, 5'd19));
    expect_frame(7'b0, "R3 hold during shift");
    pulse_rg();
    expect_frame(mk(0, 1, 5'd19), "R2 R7 R8 late +19");
    drop_rg();
    expect_frame(mk(0, 1, 5'd19), "R4 no reload on fall");
  endtask

  task automatic t_early_max();
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    expect_frame(mk(0, 1, 5'd19), "R3 hold mid-frame");
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    pulse_rg();
    expect_frame(mk(0, 0, 5'd31), "R8 early -31");
    repeat (3) @(negedge clk);
    expect_frame(mk(0, 0, 5'd31), "R4 steady high no reload");
    drop_rg();
  endtask

  task automatic t_zero_mag();
    send_frame(mk(0, 1, 5'd0)); pulse_rg();
    expect_frame(mk(0, 1, 5'd0), "R8 zero mag late");
    drop_rg();
    send_frame(mk(0, 0, 5'd0)); pulse_rg();
    expect_frame(mk(0, 0, 5'd0), "R8 zero mag early");
    drop_rg();
  endtask

  task automatic t_test_bit();
    send_frame(mk(1, 0, 5'd6)); pulse_rg();
    expect_frame(mk(1, 0, 5'd6), "R9 test bit");
    drop_rg();
  endtask

  task automatic t_enable_low();
    send_frame(mk(0, 1, 5'd10)); pulse_rg(); drop_rg();
    cr_en = 1'b0;
    send_frame(mk(1, 0, 5'd21));
    pulse_rg();
    expect_frame(mk(0, 1, 5'd10), "R6 enable low ignored");
    drop_rg();
    cr_en = 1'b1;
  endtask

  task automatic t_rg_inhibit();
    @(negedge clk); rg = 1'b1;
    send_frame(mk(1, 0, 5'd27));
    drop_rg();
    pulse_rg();
    expect_frame(mk(0, 1, 5'd10), "R5 read gate inhibits");
    drop_rg();
  endtask

  task automatic t_overlong();
    send_bit(1'b1); send_bit(1'b1);
    send_frame(mk(0, 1, 5'd5));
    pulse_rg();
    expect_frame(mk(0, 1, 5'd5), "R2 last seven bits");
    drop_rg();
  endtask

  task automatic t_coincident();
    send_frame(mk(0, 0, 5'd13));
    @(negedge clk); sdata = 1'b1; sclk = 1'b1; rg = 1'b1;
    @(negedge clk); sclk = 1'b0;
    expect_frame(mk(0, 0, 5'd13), "R11 read gate wins");
    drop_rg();
    pulse_rg(); drop_rg();
    expect_frame(mk(0, 0, 5'd13), "R11 bit not shifted");
  endtask

  task automatic t_bypass();
    send_frame(mk(1, 0, 5'd9)); pulse_rg(); drop_rg();
    expect_frame(mk(1, 0, 5'd9), "R10 preload");
    bypass = 1'b1; cr_en = 1'b0;
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    expect_frame(mk(1, 0, 5'd9), "R10 hold while zeros shift");
    pulse_rg();
    expect_frame(7'b0, "R10 nominal setting");
    drop_rg();
    bypass = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_late_load();
    t_early_max();
    t_zero_mag();
    t_test_bit();
    t_enable_low();
    t_rg_inhibit();
    t_overlong();
    t_coincident();
    t_bypass();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule